// File: doc/BRIEF.md
# Two-Operand Load Sequencer

This controller sits between an input FIFO that collects transform results and a multiply engine with separate operand-load strobes, an enable and a done flag. While idle it watches the input FIFO fill level. Once the level reaches a threshold, it fills operand bank A with `N_WORDS` words popped from the FIFO, then fills operand bank B with the next `N_WORDS` words. It then enables the engine and waits for the engine's done flag.

After done, the sequencer moves `N_WORDS` results from the engine's result stream into an output FIFO that a processor drains. A full output FIFO holds the result stream back. When the last result has been written, the sequencer returns to idle and pulses a batch-complete flag for one cycle. One counter tracks progress through the A, B and drain phases. Words move only when the source has data and the sink has room, so an empty input FIFO stalls a phase without losing its count.

Top module: `opseq_top`

## Requirements
- R1: A synchronous reset (`rst` high) returns the block to idle and clears its counter. After the first clock edge in reset, `loadA`, `loadB`, `engEn`, `inPop`, `outPush`, `engResReady` and `batchDone` are all low.
- R2: In idle, nothing is popped while `inLevel` is below `FILL_THRESH` (default `FIFO_DEPTH/2`). A level at or above the threshold starts operand A loading on the next cycle.
- R3: In phase A, each cycle with `inEmpty` low pops one word (`inPop`), drives it on `opData` and asserts `loadA` in the same cycle, until exactly `N_WORDS` words have been loaded.
- R4: Right after phase A, phase B loads exactly `N_WORDS` further words the same way with `loadB`. These words are the ones that follow the A words in FIFO order.
- R5: `inPop` is never high while `inEmpty` is high. When the FIFO runs dry partway through a phase, the phase stalls and later resumes without losing or repeating a word.
- R6: `loadA` and `loadB` are never high in the same cycle, and `loadB` is asserted only after all `N_WORDS` A words have been loaded.
- R7: `engEn` rises on the cycle after the last B load and stays high until the cycle after `engDone` is seen. It is never high while either operand is only partly loaded.
- R8: In the drain phase, `engResReady` equals the inverse of `outFull`. A result moves (`outPush` high, `outData` = `engResData`) only when `engResValid` is high and `outFull` is low.
- R9: After the `N_WORDS`-th result is pushed, the block returns to idle. `batchDone` is high for exactly the one cycle that follows the last push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inLevel | input | LVL_W | Input FIFO occupancy |
| inEmpty | input | 1 | Input FIFO empty |
| inData | input | DATA_W | Input FIFO head word |
| inPop | output | 1 | Pop strobe to the input FIFO |
| opData | output | DATA_W | Operand word to the engine |
| loadA | output | 1 | Load strobe for operand bank A |
| loadB | output | 1 | Load strobe for operand bank B |
| engEn | output | 1 | Engine enable |
| engDone | input | 1 | Engine completion flag |
| engResValid | input | 1 | Engine result available |
| engResData | input | RES_W | Engine result word |
| engResReady | output | 1 | Result accepted this cycle when valid |
| outFull | input | 1 | Output FIFO full |
| outPush | output | 1 | Push strobe to the output FIFO |
| outData | output | RES_W | Result word to the output FIFO |
| batchDone | output | 1 | One-cycle batch-complete pulse |

## Verification
The assertions check the per-cycle safety rules on every cycle: no pop from an empty FIFO, no push into a full one, never both load strobes at once, no B load or engine enable before the operand counts are complete, the one-cycle completion pulse, and quiet outputs after reset. Only the bench scenarios can show the ordering and data. These include the exact threshold at which loading starts, A words and B words taken in FIFO order across stalls, results arriving in order under output backpressure, and a reset in the middle of a batch leaving no stale count behind.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOADA,
    ST_LOADB,
    ST_RUN,
    ST_DRAIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseA;
    logic phaseB;
    logic phaseDrain;
  } seqCtrl_t;

endpackage

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     levelHit,
  input  logic     lastBeat,
  input  logic     engDone,
  output seqCtrl_t ctrl,
  output logic     engEn,
  output logic     batchDone
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (levelHit) stateNext = ST_LOADA;
      ST_LOADA: if (lastBeat) stateNext = ST_LOADB;
      ST_LOADB: if (lastBeat) stateNext = ST_RUN;
      ST_RUN:   if (engDone)  stateNext = ST_DRAIN;
      ST_DRAIN: if (lastBeat) stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      batchDone <= 1'b0;
    end else begin
      state     <= stateNext;
      batchDone <= (state == ST_DRAIN) && lastBeat;
    end
  end

  always_comb begin
    ctrl.phaseA     = (state == ST_LOADA);
    ctrl.phaseB     = (state == ST_LOADB);
    ctrl.phaseDrain = (state == ST_DRAIN);
    engEn           = (state == ST_RUN);
  end

endmodule

// File: rtl/opseq_dp.sv
module opseq_dp
  import opseq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int RES_W       = 32,
  parameter int N_WORDS     = 4096,
  parameter int LVL_W       = 14,
  parameter int FILL_THRESH = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtrl_t          ctrl,
  input  logic [LVL_W-1:0]  inLevel,
  input  logic              inEmpty,
  input  logic [DATA_W-1:0] inData,
  input  logic              engResValid,
  input  logic [RES_W-1:0]  engResData,
  input  logic              outFull,
  output logic              levelHit,
  output logic              lastBeat,
  output logic              inPop,
  output logic              loadA,
  output logic              loadB,
  output logic [DATA_W-1:0] opData,
  output logic              engResReady,
  output logic              outPush,
  output logic [RES_W-1:0]  outData
);

  localparam int CNT_W = $clog2(N_WORDS) + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_WORDS - 1);

  logic [CNT_W-1:0] beatCnt;
  logic             beatA, beatB, beatD, beat;

  assign levelHit = (inLevel >= LVL_W'(FILL_THRESH));

  always_comb begin
    beatA = ctrl.phaseA && !inEmpty;
    beatB = ctrl.phaseB && !inEmpty;
    beatD = ctrl.phaseDrain && engResValid && !outFull;
    beat  = beatA || beatB || beatD;
  end

  assign lastBeat = beat && (beatCnt == LAST_IDX);

  // one counter shared by the A, B and drain phases
  always_ff @(posedge clk) begin
    if (rst)           beatCnt <= '0;
    else if (lastBeat) beatCnt <= '0;
    else if (beat)     beatCnt <= beatCnt + CNT_W'(1);
  end

  assign inPop       = beatA || beatB;
  assign loadA       = beatA;
  assign loadB       = beatB;
  assign opData      = inData;
  assign engResReady = ctrl.phaseDrain && !outFull;
  assign outPush     = beatD;
  assign outData     = engResData;

endmodule

// File: rtl/opseq_top.sv
module opseq_top
  import opseq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int RES_W       = 32,
  parameter int N_WORDS     = 4096,
  parameter int FIFO_DEPTH  = 8192,
  parameter int FILL_THRESH = FIFO_DEPTH / 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  inLevel,
  input  logic              inEmpty,
  input  logic [DATA_W-1:0] inData,
  output logic              inPop,
  output logic [DATA_W-1:0] opData,
  output logic              loadA,
  output logic              loadB,
  output logic              engEn,
  input  logic              engDone,
  input  logic              engResValid,
  input  logic [RES_W-1:0]  engResData,
  output logic              engResReady,
  input  logic              outFull,
  output logic              outPush,
  output logic [RES_W-1:0]  outData,
  output logic              batchDone
);

  seqCtrl_t ctrl;
  logic     levelHit, lastBeat;

  opseq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .levelHit  (levelHit),
    .lastBeat  (lastBeat),
    .engDone   (engDone),
    .ctrl      (ctrl),
    .engEn     (engEn),
    .batchDone (batchDone)
  );

  opseq_dp #(
    .DATA_W      (DATA_W),
    .RES_W       (RES_W),
    .N_WORDS     (N_WORDS),
    .LVL_W       (LVL_W),
    .FILL_THRESH (FILL_THRESH)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .inLevel     (inLevel),
    .inEmpty     (inEmpty),
    .inData      (inData),
    .engResValid (engResValid),
    .engResData  (engResData),
    .outFull     (outFull),
    .levelHit    (levelHit),
    .lastBeat    (lastBeat),
    .inPop       (inPop),
    .loadA       (loadA),
    .loadB       (loadB),
    .opData      (opData),
    .engResReady (engResReady),
    .outPush     (outPush),
    .outData     (outData)
  );

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
  parameter int N_WORDS = 4096
) (
  input logic clk,
  input logic rst,
  input logic inPop,
  input logic inEmpty,
  input logic loadA,
  input logic loadB,
  input logic engEn,
  input logic engResReady,
  input logic outPush,
  input logic outFull,
  input logic batchDone
);

  // operand loads seen in the current batch
  int aSeen, bSeen;

  always_ff @(posedge clk) begin
    if (rst || batchDone) begin
      aSeen <= 0;
      bSeen <= 0;
    end else begin
      if (loadA) aSeen <= aSeen + 1;
      if (loadB) bSeen <= bSeen + 1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!loadA && !loadB && !engEn && !inPop && !outPush && !engResReady && !batchDone));

  a_r3_a_bounded: assert property (@(posedge clk) disable iff (rst)
    loadA |-> (aSeen < N_WORDS));

  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    inPop |-> !inEmpty);

  a_r6_no_dual_load: assert property (@(posedge clk) disable iff (rst)
    !(loadA && loadB));

  a_r6_b_after_a: assert property (@(posedge clk) disable iff (rst)
    loadB |-> (aSeen == N_WORDS));

  a_r7_enable_complete: assert property (@(posedge clk) disable iff (rst)
    engEn |-> (aSeen == N_WORDS && bSeen == N_WORDS));

  a_r8_push_room: assert property (@(posedge clk) disable iff (rst)
    outPush |-> !outFull);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    batchDone |=> !batchDone);

endmodule

bind opseq_top opseq_chk #(.N_WORDS(N_WORDS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inPop       (inPop),
  .inEmpty     (inEmpty),
  .loadA       (loadA),
  .loadB       (loadB),
  .engEn       (engEn),
  .engResReady (engResReady),
  .outPush     (outPush),
  .outFull     (outFull),
  .batchDone   (batchDone)
);

// File: tb/opseq_top_tb.sv
module opseq_top_tb;

  localparam int N     = 8;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int RW    = 32;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [LVL_W-1:0] inLevel = '0;
  logic             inEmpty = 1'b1;
  logic [DW-1:0]    inData = '0;
  logic             inPop, loadA, loadB, engEn, engResReady, outPush, batchDone;
  logic [DW-1:0]    opData;
  logic             engDone = 1'b0;
  logic             engResValid = 1'b0;
  logic [RW-1:0]    engResData = '0;
  logic             outFull = 1'b0;
  logic [RW-1:0]    outData;

  opseq_top #(
    .DATA_W(DW), .RES_W(RW), .N_WORDS(N), .FIFO_DEPTH(DEPTH)
  ) u_dut (
    .clk(clk), .rst(rst), .inLevel(inLevel), .inEmpty(inEmpty), .inData(inData),
    .inPop(inPop), .opData(opData), .loadA(loadA), .loadB(loadB), .engEn(engEn),
    .engDone(engDone), .engResValid(engResValid), .engResData(engResData),
    .engResReady(engResReady), .outFull(outFull), .outPush(outPush),
    .outData(outData), .batchDone(batchDone)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [DW-1:0] wordsQ[$], feedQ[$], inQ[$], expOp[$], engA[$], engB[$];
  logic [RW-1:0] resQ[$], expRes[$];

  bit popPend = 0, resPend = 0, doneNext = 0, holdFull = 0, fullPattern = 0;
  int cyc = 0, engCnt = -1, sz = 0;
  int loadsA = 0, loadsB = 0, pushes = 0, doneCnt = 0, lastPushCyc = -10;

  // FIFO models, stand-in engine and monitor, all away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (popPend && inQ.size() > 0) void'(inQ.pop_front());
    if (resPend && resQ.size() > 0) void'(resQ.pop_front());
    while (feedQ.size() > 0) inQ.push_back(feedQ.pop_front());
    sz = inQ.size();
    inEmpty = (sz == 0);
    inLevel = LVL_W'((sz > DEPTH) ? DEPTH : sz);
    inData  = inEmpty ? '0 : inQ[0];
    engDone = doneNext;
    doneNext = 0;
    engResValid = (resQ.size() > 0);
    engResData  = engResValid ? resQ[0] : '0;
    outFull = holdFull || (fullPattern && (cyc % 3) != 0);
    #1;
    popPend = 0;
    resPend = 0;
    if (!rst) begin
      popPend = inPop;
      resPend = engResValid && engResReady;
      if (inPop) chk(!inEmpty, "R5 pop while empty", inEmpty, 0);
      if (inPop || loadA || loadB) chk(inPop == (loadA || loadB), "R3 pop matches load", inPop, loadA || loadB);
      if (loadA && loadB) chk(0, "R6 dual load", 1, 0);
      if (loadA) begin
        chk(loadsB == 0, "R6 A after B", loadsB, 0);
        chk(expOp.size() > 0 && opData == expOp[0], "R3 A word", opData, expOp.size() > 0 ? expOp[0] : 0);
        if (expOp.size() > 0) void'(expOp.pop_front());
        engA.push_back(opData);
        loadsA++;
      end else if (loadB) begin
        chk(loadsA == N, "R6 B before A complete", loadsA, N);
        chk(expOp.size() > 0 && opData == expOp[0], "R4 B word", opData, expOp.size() > 0 ? expOp[0] : 0);
        if (expOp.size() > 0) void'(expOp.pop_front());
        engB.push_back(opData);
        loadsB++;
      end
      if (engEn && engCnt < 0 && !engDone) begin
        chk(loadsA == N && loadsB == N, "R7 enable before operands full", loadsA + loadsB, 2 * N);
        engCnt = 3;
      end else if (engCnt > 0) begin
        engCnt--;
      end else if (engCnt == 0) begin
        chk(engEn, "R7 enable held while waiting", engEn, 1);
        for (int i = 0; i < engA.size() && i < engB.size(); i++)
          resQ.push_back(RW'(engA[i]) * RW'(engB[i]));
        engA.delete();
        engB.delete();
        doneNext = 1;
        engCnt = -1;
      end
      if (engResReady || outPush)
        chk(outPush == (engResValid && engResReady) && engResReady == !outFull,
            "R8 handshake", outPush, engResValid && !outFull);
      if (outPush) begin
        chk(expRes.size() > 0 && outData == expRes[0], "R8 result", outData,
            expRes.size() > 0 ? expRes[0] : 0);
        if (expRes.size() > 0) void'(expRes.pop_front());
        pushes++;
        lastPushCyc = cyc;
      end
      if (batchDone) begin
        doneCnt++;
        chk(pushes == N, "R9 pushes before done", pushes, N);
        chk(lastPushCyc == cyc - 1, "R9 done timing", cyc - lastPushCyc, 1);
        loadsA = 0;
        loadsB = 0;
        pushes = 0;
      end
    end
  end

  // driver: builds a batch and the expected items
  task automatic prepBatch(input int seed);
    logic [DW-1:0] w[2*N];
    for (int i = 0; i < 2 * N; i++) begin
      w[i] = DW'(seed * 97 + i * 31 + 5);
      wordsQ.push_back(w[i]);
      expOp.push_back(w[i]);
    end
    for (int i = 0; i < N; i++) expRes.push_back(RW'(w[i]) * RW'(w[N + i]));
  endtask

  task automatic feed(input int count);
    for (int i = 0; i < count && wordsQ.size() > 0; i++) feedQ.push_back(wordsQ.pop_front());
  endtask

  task automatic waitDone(input int target, input string req);
    for (int i = 0; i < 3000 && doneCnt < target; i++) @(negedge clk);
    chk(doneCnt == target, req, doneCnt, target);
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1: outputs quiet during reset
    chk(!loadA && !loadB && !engEn && !inPop && !outPush && !batchDone && !engResReady,
        "R1 reset outputs", {loadA, loadB, engEn, inPop, outPush, batchDone}, 0);
    @(negedge clk);
    rst = 1'b0;

    // batch 1: threshold and stalls
    prepBatch(1);
    feed(N - 1);
    repeat (20) @(negedge clk);
    chk(loadsA == 0, "R2 no load below threshold", loadsA, 0);
    feed(1);
    repeat (6) @(negedge clk);
    chk(loadsA > 0, "R2 load starts at threshold", loadsA, N);
    repeat (10) @(negedge clk);
    chk(loadsA == N && loadsB == 0, "R5 stall holds after A", loadsB, 0);
    feed(3);
    repeat (12) @(negedge clk);
    chk(loadsB == 3, "R5 stall inside B", loadsB, 3);
    chk(!engEn, "R7 no enable while B partial", engEn, 0);
    feed(N - 3);
    waitDone(1, "R9 batch 1 completes");

    // batch 2: bursty output backpressure
    fullPattern = 1;
    prepBatch(2);
    feed(2 * N);
    waitDone(2, "R8 batch 2 completes under backpressure");
    fullPattern = 0;

    // batch 3: reset partway through operand A
    prepBatch(3);
    feed(2 * N);
    for (int i = 0; i < 200 && loadsA < 3; i++) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(!loadA && !loadB && !engEn && !inPop, "R1 mid-batch reset", {loadA, loadB, engEn, inPop}, 0);
    inQ.delete(); feedQ.delete(); wordsQ.delete(); expOp.delete(); expRes.delete();
    engA.delete(); engB.delete(); resQ.delete();
    engCnt = -1; loadsA = 0; loadsB = 0; pushes = 0;
    @(negedge clk);
    rst = 1'b0;

    // batch 4: clean run after reset, output held full for a while
    prepBatch(4);
    feed(2 * N);
    for (int i = 0; i < 500 && !engEn; i++) @(negedge clk);
    holdFull = 1;
    repeat (15) @(negedge clk);
    chk(pushes == 0, "R8 held full blocks push", pushes, 0);
    holdFull = 0;
    waitDone(3, "R1 counter clear gives full batch after reset");

    repeat (5) @(negedge clk);
    chk(expOp.size() == 0, "R4 all operand words consumed", expOp.size(), 0);
    chk(expRes.size() == 0, "R9 all results delivered", expRes.size(), 0);
    chk(!batchDone && !engEn, "R9 idle after batch", {batchDone, engEn}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule